// File: doc/BRIEF.md
# DDR SDRAM command and bank tracker

This block listens to the command pins of a DDR SDRAM device on every rising clock edge and keeps a running picture of the four internal banks. For each bank it records whether a row is open, which row that is, and whether an access with automatic close is still in flight. For every sampled cycle it reports which command was seen, the bank it addressed, the burst start column and the row involved. An error pulse marks any command that the current bank state makes illegal.

The tracker is a passive observer. It is meant for a memory-side model, a protocol monitor or a controller shadow that must agree with the device about bank state. It also keeps the programmed burst length, because that length sets how long an auto-closing access keeps its bank open. Data, strobes, delay lines, analogue timing and refresh scheduling are out of its scope.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After a synchronous reset all banks are closed with no pending close, every stored row is 0, `o_cmd` is 0, `o_err` is 0 and `o_burst_len` is 4.
- R2: The edge after a command is sampled, `o_cmd` shows its code. With {ras_n,cas_n,we_n} = 111 the code is NOP=0, 011 gives ACTIVATE=1, 101 gives READ=2, 100 gives WRITE=3, 010 gives PRECHARGE=4, 001 gives REFRESH=5, 000 gives MODE SET=6 and 110 gives BURST STOP=7.
- R3: With cs_n high the command and address inputs are ignored. `o_cmd`, `o_bank`, `o_col`, `o_row`, `o_ap` and `o_err` are 0, and no bank changes state. The only exception is that pending auto-closes keep counting down.
- R4: The bank index is {ba[1], ba[0]}, so ba=01 selects bank 1 (bit 1 of `o_bank_open`) and ba=10 selects bank 2.
- R5: A legal ACTIVATE opens the selected bank and stores all 13 address bits as its row. `o_row` reports the address on ACTIVATE.
- R6: On READ or WRITE, `o_col` carries addr[9:0], `o_ap` carries addr[10] and `o_row` carries the row stored for the selected bank.
- R7: PRECHARGE with addr[10]=1 closes every bank. With addr[10]=0 it closes only the selected bank. It is never an error, and it cancels any pending auto-close on the banks it closes.
- R8: A legal READ or WRITE with addr[10]=1 marks its bank pending. The bank closes at the clock edge that lies burst_length/2 edges after the command edge.
- R9: READ or WRITE to a closed or pending bank, and ACTIVATE to an open bank, raise `o_err` for one cycle and change no bank state.
- R10: REFRESH and MODE SET are legal only when all banks are closed. Otherwise they raise `o_err` and have no effect.
- R11: A legal MODE SET with ba=00 loads the burst length from addr[2:0]: 001 gives 2, 010 gives 4 and 011 gives 8. Any other code leaves it unchanged. ba other than 00 leaves it unchanged.
- R12: NOP and BURST STOP change no bank state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row / column / control address |
| o_cmd | output | 3 | Decoded command code |
| o_bank | output | 2 | Bank addressed by the command |
| o_col | output | 10 | Burst start column on READ/WRITE |
| o_row | output | 13 | Row for ACTIVATE or for the accessed bank |
| o_ap | output | 1 | Auto-close requested on READ/WRITE |
| o_err | output | 1 | Illegal command pulse |
| o_bank_open | output | 4 | Per-bank open flag |
| o_ap_pend | output | 4 | Per-bank pending auto-close flag |
| o_burst_len | output | 4 | Programmed burst length (2, 4 or 8) |

## Verification
Directed sequences come first. They walk the bank index mapping, an auto-close at burst lengths 2 and 8 (the second spanning deselected cycles), double activates, refresh with a bank open, and both forms of precharge. This separates counting errors from decode and priority errors. Constrained random traffic then mixes all eight commands with deselects and random banks and addresses. Every cycle is compared against a bench model of the bank records. Random traffic reaches combinations such as a precharge landing on a pending bank and accesses hitting a bank in its last pending cycle, which the directed part cannot enumerate.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_BST  = 3'd7
  } cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_burst_cfg.sv
module ddr_burst_cfg #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [2:0]       code,
  output logic [LEN_W-1:0] burst_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      burst_len <= LEN_W'(4);
    end else if (load) begin
      case (code)
        3'b001:  burst_len <= LEN_W'(2);
        3'b010:  burst_len <= LEN_W'(4);
        3'b011:  burst_len <= LEN_W'(8);
        default: burst_len <= burst_len;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             close_en,
  input  logic             act_en,
  input  logic [ROW_W-1:0] act_row,
  input  logic             ap_set,
  input  logic [CNT_W-1:0] ap_cycles,
  output logic             is_open,
  output logic             ap_pend,
  output logic [ROW_W-1:0] row
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      ap_pend <= 1'b0;
      cnt     <= '0;
      row     <= '0;
    end else if (close_en) begin
      is_open <= 1'b0;
      ap_pend <= 1'b0;
    end else if (act_en) begin
      is_open <= 1'b1;
      row     <= act_row;
    end else if (ap_set) begin
      ap_pend <= 1'b1;
      cnt     <= ap_cycles;
    end else if (ap_pend) begin
      if (cnt <= CNT_W'(1)) begin
        is_open <= 1'b0;
        ap_pend <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_trk_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int LEN_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [2:0]             o_cmd,
  output logic [BA_W-1:0]        o_bank,
  output logic [COL_W-1:0]       o_col,
  output logic [ROW_W-1:0]       o_row,
  output logic                   o_ap,
  output logic                   o_err,
  output logic [(1<<BA_W)-1:0]   o_bank_open,
  output logic [(1<<BA_W)-1:0]   o_ap_pend,
  output logic [LEN_W-1:0]       o_burst_len
);
  localparam int NB    = 1 << BA_W;
  localparam int CNT_W = LEN_W - 1;

  cmd_e             cmd;
  logic [NB-1:0]    open_vec;
  logic [NB-1:0]    pend_vec;
  logic [ROW_W-1:0] row_vec [NB];
  logic [NB-1:0]    close_en, act_en, ap_set;
  logic             is_rw, any_open, sel_open, sel_pend;
  logic             rw_ok, err_now, mrs_load;
  logic [LEN_W-1:0] burst_len;

  ddr_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
  );

  ddr_burst_cfg #(.LEN_W(LEN_W)) u_cfg (
    .clk (clk), .rst (rst), .load (mrs_load), .code (addr[2:0]),
    .burst_len (burst_len)
  );

  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign any_open = |open_vec;
  assign sel_open = open_vec[ba];
  assign sel_pend = pend_vec[ba];
  assign rw_ok    = is_rw && sel_open && !sel_pend;
  assign mrs_load = (cmd == CMD_MRS) && !any_open && (ba == '0);

  always_comb begin
    err_now = 1'b0;
    unique case (cmd)
      CMD_ACT:          err_now = sel_open;
      CMD_RD, CMD_WR:   err_now = !sel_open || sel_pend;
      CMD_REF, CMD_MRS: err_now = any_open;
      default:          err_now = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign close_en[i] = (cmd == CMD_PRE) && (addr[AP_BIT] || (ba == BA_W'(i)));
    assign act_en[i]   = (cmd == CMD_ACT) && !open_vec[i] && (ba == BA_W'(i));
    assign ap_set[i]   = rw_ok && addr[AP_BIT] && (ba == BA_W'(i));

    ddr_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .close_en  (close_en[i]),
      .act_en    (act_en[i]),
      .act_row   (addr),
      .ap_set    (ap_set[i]),
      .ap_cycles (burst_len[LEN_W-1:1]),
      .is_open   (open_vec[i]),
      .ap_pend   (pend_vec[i]),
      .row       (row_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_cmd  <= CMD_NOP;
      o_bank <= '0;
      o_col  <= '0;
      o_row  <= '0;
      o_ap   <= 1'b0;
      o_err  <= 1'b0;
    end else begin
      o_cmd  <= cmd;
      o_bank <= cs_n ? '0 : ba;
      o_col  <= is_rw ? addr[COL_W-1:0] : '0;
      o_ap   <= is_rw && addr[AP_BIT];
      o_row  <= (cmd == CMD_ACT) ? addr : (is_rw ? row_vec[ba] : '0);
      o_err  <= err_now;
    end
  end

  assign o_bank_open = open_vec;
  assign o_ap_pend   = pend_vec;
  assign o_burst_len = burst_len;
endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
  parameter int BA_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic                 ap_bit,
  input logic [2:0]           o_cmd,
  input logic                 o_err,
  input logic [(1<<BA_W)-1:0] o_bank_open,
  input logic [(1<<BA_W)-1:0] o_ap_pend
);
  logic [2:0] pins;
  assign pins = {ras_n, cas_n, we_n};

  // R9: activate on an open bank is flagged
  a_r9_act_open_err: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && pins == 3'b011 && o_bank_open[ba]) |=> o_err);

  // R5: legal activate opens the addressed bank
  a_r5_act_opens: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && pins == 3'b011 && !o_bank_open[ba]) |=> o_bank_open[$past(ba)]);

  // R3: deselected cycle reports nothing
  a_r3_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!o_err && o_cmd == 3'd0));

  // R7: precharge-all closes everything
  a_r7_pre_all: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && pins == 3'b010 && ap_bit) |=> (o_bank_open == '0));

  // R8: a pending close only exists on an open bank
  a_r8_pend_open: assert property (@(posedge clk) disable iff (rst)
    ((o_ap_pend & ~o_bank_open) == '0));

  // R10: refresh with any bank open is flagged
  a_r10_ref_busy: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && pins == 3'b001 && (|o_bank_open)) |=> o_err);
endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.BA_W(BA_W)) u_chk (
  .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
  .we_n (we_n), .ba (ba), .ap_bit (addr[AP_BIT]), .o_cmd (o_cmd),
  .o_err (o_err), .o_bank_open (o_bank_open), .o_ap_pend (o_ap_pend)
);

// File: tb/ddr_bank_tracker_bench.sv
`timescale 1ns/1ps
module ddr_bank_tracker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [2:0]  o_cmd;
  logic [1:0]  o_bank;
  logic [9:0]  o_col;
  logic [12:0] o_row;
  logic        o_ap, o_err;
  logic [3:0]  o_bank_open, o_ap_pend, o_burst_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_open [4];
  int m_pend [4];
  int m_cnt  [4];
  int m_row  [4];
  int m_bl;
  int e_cmd, e_bank, e_col, e_row, e_ap, e_err;

  always #2.5 clk = ~clk;

  ddr_bank_tracker u_ddr_bank_tracker (
    .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .ba (ba), .addr (addr), .o_cmd (o_cmd), .o_bank (o_bank),
    .o_col (o_col), .o_row (o_row), .o_ap (o_ap), .o_err (o_err),
    .o_bank_open (o_bank_open), .o_ap_pend (o_ap_pend),
    .o_burst_len (o_burst_len)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pack4(input int v [4]);
    int r = 0;
    for (int i = 0; i < 4; i++) if (v[i] != 0) r |= (1 << i);
    return r;
  endfunction

  function automatic string tag_of();
    if (cs_n) return "R3";
    case ({ras_n, cas_n, we_n})
      3'b011: return "R5";
      3'b101, 3'b100: return "R6";
      3'b010: return "R7";
      3'b001, 3'b000: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; m_row[i] = 0;
    end
    m_bl = 4;
  endtask

  // Reference update for one sampled edge
  task automatic model_step();
    bit touched [4];
    int b = int'(ba);
    int a = int'(addr);
    int any_open = pack4(m_open) != 0;
    for (int i = 0; i < 4; i++) touched[i] = 0;
    e_cmd = 0; e_bank = 0; e_col = 0; e_row = 0; e_ap = 0; e_err = 0;
    if (!cs_n) begin
      e_bank = b;
      case ({ras_n, cas_n, we_n})
        3'b011: begin
          e_cmd = 1; e_row = a;
          if (m_open[b] != 0) e_err = 1;
          else begin m_open[b] = 1; m_row[b] = a; touched[b] = 1; end
        end
        3'b101, 3'b100: begin
          e_cmd = ras_n && !cas_n && we_n ? 2 : 3;
          e_col = a & 1023; e_ap = (a >> 10) & 1; e_row = m_row[b];
          if (m_open[b] == 0 || m_pend[b] != 0) e_err = 1;
          else if (e_ap != 0) begin m_pend[b] = 1; m_cnt[b] = m_bl / 2; touched[b] = 1; end
        end
        3'b010: begin
          e_cmd = 4;
          for (int i = 0; i < 4; i++)
            if (((a >> 10) & 1) != 0 || i == b) begin
              m_open[i] = 0; m_pend[i] = 0; touched[i] = 1;
            end
        end
        3'b001: begin e_cmd = 5; e_err = any_open; end
        3'b000: begin
          e_cmd = 6;
          if (any_open != 0) e_err = 1;
          else if (b == 0) begin
            case (a & 7)
              1: m_bl = 2;
              2: m_bl = 4;
              3: m_bl = 8;
              default: ;
            endcase
          end
        end
        3'b110: e_cmd = 7;
        default: e_cmd = 0;
      endcase
    end
    for (int i = 0; i < 4; i++)
      if (!touched[i] && m_pend[i] != 0) begin
        if (m_cnt[i] <= 1) begin m_open[i] = 0; m_pend[i] = 0; end
        else m_cnt[i]--;
      end
  endtask

  task automatic compare_all(input string req);
    chk(req, "cmd (R2)", int'(o_cmd), e_cmd);
    chk(req, "bank (R4)", int'(o_bank), e_bank);
    chk(req, "col", int'(o_col), e_col);
    chk(req, "row", int'(o_row), e_row);
    chk(req, "ap", int'(o_ap), e_ap);
    chk(req, "err (R9)", int'(o_err), e_err);
    chk(req, "open", int'(o_bank_open), pack4(m_open));
    chk(req, "pend (R8)", int'(o_ap_pend), pack4(m_pend));
    chk(req, "burst (R11)", int'(o_burst_len), m_bl);
  endtask

  task automatic drive(input logic c, input logic [2:0] p, input logic [1:0] b,
                       input logic [12:0] a);
    string req;
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr = a;
    req = tag_of();
    @(posedge clk);
    model_step();
    #1;
    compare_all(req);
  endtask

  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101,
                         P_WR = 3'b100, P_PRE = 3'b010, P_REF = 3'b001,
                         P_MRS = 3'b000, P_BST = 3'b110;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "open", int'(o_bank_open), 0);
    chk("R1", "pend", int'(o_ap_pend), 0);
    chk("R1", "err", int'(o_err), 0);
    chk("R1", "cmd", int'(o_cmd), 0);
    chk("R1", "burst", int'(o_burst_len), 4);

    // R11: burst length 2
    drive(0, P_MRS, 2'b00, 13'h001);
    chk("R11", "bl=2", int'(o_burst_len), 2);
    // R4: ba=01 is bank 1, ba=10 is bank 2
    drive(0, P_ACT, 2'b01, 13'h1ABC);
    chk("R4", "bank1 open", int'(o_bank_open), 4'b0010);
    drive(0, P_ACT, 2'b10, 13'h0123);
    chk("R4", "bank2 open", int'(o_bank_open), 4'b0110);
    // R6: read bank 1 with auto-close
    drive(0, P_RD, 2'b01, 13'h0555);
    chk("R6", "col", int'(o_col), 13'h0555 & 10'h3FF);
    chk("R6", "row", int'(o_row), 13'h1ABC);
    chk("R8", "still open", int'(o_bank_open[1]), 1);
    drive(0, P_NOP, 2'b00, 13'h0);
    chk("R8", "closed after BL/2=1", int'(o_bank_open[1]), 0);
    // R9: double activate
    drive(0, P_ACT, 2'b01, 13'h0077);
    drive(0, P_ACT, 2'b01, 13'h0088);
    chk("R9", "err on open act", int'(o_err), 1);
    drive(0, P_RD, 2'b01, 13'h0);
    chk("R9", "row kept", int'(o_row), 13'h0077);
    drive(0, P_WR, 2'b11, 13'h0);
    chk("R9", "write closed bank", int'(o_err), 1);
    // R10: refresh with banks open
    drive(0, P_REF, 2'b00, 13'h0);
    chk("R10", "refresh busy", int'(o_err), 1);
    // R7: precharge single, then all
    drive(0, P_PRE, 2'b10, 13'h0000);
    chk("R7", "single", int'(o_bank_open), 4'b0010);
    drive(0, P_PRE, 2'b00, 13'h0400);
    chk("R7", "all", int'(o_bank_open), 0);
    drive(0, P_REF, 2'b00, 13'h0);
    chk("R10", "refresh idle", int'(o_err), 0);
    // R11: burst length 8, then an invalid code keeps it
    drive(0, P_MRS, 2'b00, 13'h003);
    chk("R11", "bl=8", int'(o_burst_len), 8);
    drive(0, P_MRS, 2'b00, 13'h007);
    chk("R11", "bad code", int'(o_burst_len), 8);
    drive(0, P_MRS, 2'b01, 13'h001);
    chk("R11", "ext bank", int'(o_burst_len), 8);
    // R3 + R8: deselects while a BL=8 auto-close counts down
    drive(0, P_ACT, 2'b11, 13'h1FFF);
    drive(0, P_WR, 2'b11, 13'h07FF);
    for (int k = 0; k < 3; k++) begin
      drive(1, P_ACT, 2'b11, 13'h0);
      chk("R3", "pending kept", int'(o_ap_pend[3]), 1);
    end
    drive(1, P_PRE, 2'b11, 13'h0400);
    chk("R8", "closed after 4", int'(o_bank_open[3]), 0);
    chk("R3", "cmd quiet", int'(o_cmd), 0);
    // R12: NOP and burst stop leave state
    drive(0, P_ACT, 2'b00, 13'h0042);
    drive(0, P_BST, 2'b00, 13'h0400);
    chk("R12", "bst", int'(o_bank_open), 4'b0001);
    drive(0, P_NOP, 2'b00, 13'h0400);
    chk("R12", "nop", int'(o_err), 0);

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 16;
      int s = $urandom % 16;
      logic [2:0] p;
      logic [12:0] a = 13'($urandom);
      if (s < 4) p = P_ACT;
      else if (s < 7) p = P_RD;
      else if (s < 10) p = P_WR;
      else if (s < 12) p = P_PRE;
      else if (s == 12) p = P_REF;
      else if (s == 13) p = P_MRS;
      else if (s == 14) p = P_NOP;
      else p = P_BST;
      if (p == P_PRE && ($urandom % 4) != 0) a[10] = 1'b0;
      drive(r < 2, p, 2'($urandom), a);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule